// File: doc/BRIEF.md
# DDR2 Mode Register Programming Sequencer

This block sits on the controller side of a DDR2 memory interface. It programs the device's four mode registers once the memory is ready. A single `start` pulse hands it a configuration: read latency, additive latency, burst length, write-recovery cycles and termination strength. The block first checks that configuration. A bad request is refused with a one-cycle `rejected` pulse, and nothing is driven onto the command bus.

A good request is latched. The block then waits until the controller reports that every bank is precharged and the clock-enable pin is high. It then issues five register-set commands in a fixed order:

1. The base register.
2. The first extended register, with driver calibration set to its default.
3. The first extended register again, leaving calibration with the other fields unchanged.
4. The second extended register.
5. The third extended register.

Between any two writes it holds the bus on no-operation for the programmed command spacing. When the spacing after the last write has elapsed, it pulses `done`.

The command bus is registered: every output changes only on a rising clock edge. Outside a sequence the bus shows deselect (chip select high).

Top module: `ddr2_mrs_seq`

## Requirements
- R1: While reset is held and afterwards with no start, `cs_n` is 1, `ba` and `addr` are 0, and `done` and `rejected` are 0.
- R2: A register write is `cs_n`, `ras_n`, `cas_n` and `we_n` all 0. A sequence contains exactly five writes with `ba` = 0, 1, 1, 2, 3 in that order. The bus never shows any other command with both `cs_n` and `ras_n` low.
- R3: The base-register write carries burst length on `addr[2:0]` (010 for 4, 011 for 8), `addr[3]` = 0, the read latency in binary on `addr[6:4]`, `addr[8:7]` = 0, write recovery minus one on `addr[11:9]`, and 0 above.
- R4: Both first-extended writes carry additive latency on `addr[5:3]` and the termination code on {`addr[6]`,`addr[2]`}. The codes are 00 off, 01 75 ohm, 10 150 ohm and 11 50 ohm. All other bits are 0 except `addr[9:7]`, which is 111 in the first of the two writes and 000 in the second.
- R5: The second- and third-extended writes carry `addr` = 0.
- R6: Consecutive writes start exactly TMRD cycles apart. Every cycle between them shows no-operation: `cs_n` = 0, `ras_n`/`cas_n`/`we_n` = 1, `addr` = 0.
- R7: No write is issued before a rising edge at which `banks_idle` and `cke_on` are both 1. Until then the bus shows deselect. The first write appears the cycle after the first such edge.
- R8: A request is refused if read latency is outside 3..6, additive latency above 5, burst length other than 4 or 8, or write recovery outside 2..6. A refusal gives `rejected` = 1 for one cycle, the cycle after `start`, with no write and no `done`.
- R9: While a sequence runs, `start` is ignored, and changes on the configuration inputs do not alter the words written.
- R10: `done` is 1 for exactly one cycle, TMRD cycles after the last write, with the bus at deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a programming sequence (sampled when idle) |
| cas_lat | input | 3 | Requested read latency in cycles |
| add_lat | input | 3 | Requested additive latency in cycles |
| burst_len | input | 4 | Requested burst length in beats |
| wr_rec | input | 3 | Requested write recovery in cycles |
| term_code | input | 2 | Termination code: 0 off, 1 75 ohm, 2 150 ohm, 3 50 ohm |
| banks_idle | input | 1 | All banks are precharged |
| cke_on | input | 1 | Clock enable to the memory is high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, selects the target register |
| addr | output | ADDR_W | Address bus, carries the register contents |
| done | output | 1 | One-cycle pulse when the sequence is complete |
| rejected | output | 1 | One-cycle pulse when a request is refused |

## Verification
A step counter that skips or repeats shows up in the very cycle a write is issued: the bank-address order on the bus breaks, or the write count differs from five. A wrong spacing counter shows up at the second write, because its start cycle is off by one or more. A dropped latch of the configuration only shows up in the written words, and only when the inputs change during the run. The bench therefore disturbs them mid-sequence and compares every address word against values derived from the field layout.

// File: rtl/ddr2_mrs_pkg.sv
package ddr2_mrs_pkg;

    // Write steps, in issue order; STEP_END marks the sequence as finished.
    localparam int STEP_W = 3;
    localparam logic [STEP_W-1:0] STEP_MR      = 3'd0;
    localparam logic [STEP_W-1:0] STEP_E1_DEF  = 3'd1;
    localparam logic [STEP_W-1:0] STEP_E1_EXIT = 3'd2;
    localparam logic [STEP_W-1:0] STEP_E2      = 3'd3;
    localparam logic [STEP_W-1:0] STEP_E3      = 3'd4;
    localparam logic [STEP_W-1:0] STEP_END     = 3'd5;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_GAP
    } seq_state_t;

    // Configuration as latched at start.
    typedef struct packed {
        logic [2:0] cl;
        logic [2:0] al;
        logic       bl8;
        logic [2:0] wr;
        logic [1:0] term;
    } mrs_cfg_t;

endpackage

// File: rtl/mrs_cfg_check.sv
module mrs_cfg_check
    import ddr2_mrs_pkg::*;
#(
    parameter int CL_MIN = 3,
    parameter int CL_MAX = 6,
    parameter int AL_MAX = 5,
    parameter int WR_MIN = 2,
    parameter int WR_MAX = 6
) (
    input  logic [2:0] cas_lat,
    input  logic [2:0] add_lat,
    input  logic [3:0] burst_len,
    input  logic [2:0] wr_rec,
    input  logic [1:0] term_code,
    output logic       cfg_ok,
    output mrs_cfg_t   cfg
);

    logic cl_ok, al_ok, bl_ok, wr_ok;

    always_comb begin
        cl_ok  = (cas_lat >= 3'(CL_MIN)) && (cas_lat <= 3'(CL_MAX));
        al_ok  = (add_lat <= 3'(AL_MAX));
        bl_ok  = (burst_len == 4'd4) || (burst_len == 4'd8);
        wr_ok  = (wr_rec >= 3'(WR_MIN)) && (wr_rec <= 3'(WR_MAX));
        cfg_ok = cl_ok && al_ok && bl_ok && wr_ok;

        cfg.cl   = cas_lat;
        cfg.al   = add_lat;
        cfg.bl8  = (burst_len == 4'd8);
        cfg.wr   = wr_rec;
        cfg.term = term_code;
    end

endmodule

// File: rtl/mrs_word_gen.sv
module mrs_word_gen
    import ddr2_mrs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic [STEP_W-1:0] step,
    input  mrs_cfg_t          cfg,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        ba   = '0;
        addr = '0;
        case (step)
            STEP_MR: begin
                ba          = BA_W'(0);
                addr[2:0]   = cfg.bl8 ? 3'b011 : 3'b010;
                addr[3]     = 1'b0;               // sequential ordering
                addr[6:4]   = cfg.cl;
                addr[11:9]  = cfg.wr - 3'd1;
            end
            STEP_E1_DEF, STEP_E1_EXIT: begin
                ba          = BA_W'(1);
                addr[2]     = cfg.term[0];
                addr[6]     = cfg.term[1];
                addr[5:3]   = cfg.al;
                addr[9:7]   = (step == STEP_E1_DEF) ? 3'b111 : 3'b000;
            end
            STEP_E2: ba = BA_W'(2);
            STEP_E3: ba = BA_W'(3);
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr2_mrs_seq.sv
module ddr2_mrs_seq
    import ddr2_mrs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int TMRD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cas_lat,
    input  logic [2:0]        add_lat,
    input  logic [3:0]        burst_len,
    input  logic [2:0]        wr_rec,
    input  logic [1:0]        term_code,
    input  logic              banks_idle,
    input  logic              cke_on,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              rejected
);

    localparam int CNT_W   = (TMRD > 1) ? $clog2(TMRD) : 1;
    localparam int SINCE_W = $clog2(TMRD + 1);

    typedef struct packed {
        seq_state_t        st;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  gap;
        mrs_cfg_t          cfg;
        logic              cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              rej;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              in_ok;
    mrs_cfg_t          in_cfg;
    logic [BA_W-1:0]   wg_ba;
    logic [ADDR_W-1:0] wg_addr;
    logic              do_issue;

    mrs_cfg_check u_check (
        .cas_lat   (cas_lat),
        .add_lat   (add_lat),
        .burst_len (burst_len),
        .wr_rec    (wr_rec),
        .term_code (term_code),
        .cfg_ok    (in_ok),
        .cfg       (in_cfg)
    );

    mrs_word_gen #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_words (
        .step (r_q.step),
        .cfg  (r_q.cfg),
        .ba   (wg_ba),
        .addr (wg_addr)
    );

    always_comb begin
        r_d      = r_q;
        do_issue = 1'b0;
        r_d.done = 1'b0;
        r_d.rej  = 1'b0;
        // deselect unless overridden below
        r_d.cs_n  = 1'b1;
        r_d.ras_n = 1'b1;
        r_d.cas_n = 1'b1;
        r_d.we_n  = 1'b1;
        r_d.ba    = '0;
        r_d.addr  = '0;

        case (r_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    if (in_ok) begin
                        r_d.cfg  = in_cfg;
                        r_d.step = STEP_MR;
                        r_d.st   = SEQ_WAIT;
                    end else begin
                        r_d.rej = 1'b1;
                    end
                end
            end
            SEQ_WAIT: begin
                if (banks_idle && cke_on) do_issue = 1'b1;
            end
            SEQ_GAP: begin
                r_d.cs_n = 1'b0;            // no-operation while spacing
                if (r_q.gap != '0) begin
                    r_d.gap = r_q.gap - 1'b1;
                end else if (r_q.step == STEP_END) begin
                    r_d.cs_n = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = SEQ_IDLE;
                end else begin
                    do_issue = 1'b1;
                end
            end
            default: r_d.st = SEQ_IDLE;
        endcase

        if (do_issue) begin
            r_d.cs_n  = 1'b0;
            r_d.ras_n = 1'b0;
            r_d.cas_n = 1'b0;
            r_d.we_n  = 1'b0;
            r_d.ba    = wg_ba;
            r_d.addr  = wg_addr;
            r_d.step  = r_q.step + 1'b1;
            r_d.gap   = CNT_W'(TMRD - 1);
            r_d.st    = SEQ_GAP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= SEQ_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.ras_n <= 1'b1;
            r_q.cas_n <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n     = r_q.cs_n;
    assign ras_n    = r_q.ras_n;
    assign cas_n    = r_q.cas_n;
    assign we_n     = r_q.we_n;
    assign ba       = r_q.ba;
    assign addr     = r_q.addr;
    assign done     = r_q.done;
    assign rejected = r_q.rej;

    // ---------------- checks ----------------
    logic               mrs_vis;
    logic [SINCE_W-1:0] since_q;
    logic               seen_q;

    assign mrs_vis = !cs_n && !ras_n && !cas_n && !we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (mrs_vis) begin
            since_q <= SINCE_W'(1);
            seen_q  <= 1'b1;
        end else if (since_q < SINCE_W'(TMRD)) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_ONLY_MRS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n) |-> (!cas_n && !we_n));                   // R2
    AST_MRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_vis && seen_q) |-> (since_q >= SINCE_W'(TMRD)));       // R6
    AST_READY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_vis && ba == '0) |-> $past(banks_idle && cke_on));     // R7
    AST_REJ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> (cs_n && !done));                              // R8
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != SEQ_IDLE && r_q.st == $past(r_q.st)
         && $past(r_q.st) == SEQ_GAP) |-> $stable(r_q.cfg));        // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                            // R10
    AST_DONE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);                                             // R10

endmodule

// File: tb/ddr2_mrs_seq_test.sv
module ddr2_mrs_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int TMRD_T     = 2;
    localparam int AW         = 13;
    localparam int NVEC       = 8;

    // {ok, cl[2:0], al[2:0], bl[3:0], wr[2:0], term[1:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 3'd3, 3'd0, 4'd4, 3'd2, 2'd0},
        {1'b1, 3'd6, 3'd5, 4'd8, 3'd6, 2'd3},
        {1'b1, 3'd4, 3'd2, 4'd8, 3'd3, 2'd1},
        {1'b1, 3'd5, 3'd1, 4'd4, 3'd5, 2'd2},
        {1'b0, 3'd2, 3'd0, 4'd4, 3'd3, 2'd1},
        {1'b0, 3'd5, 3'd6, 4'd8, 3'd3, 2'd0},
        {1'b0, 3'd4, 3'd0, 4'd5, 3'd3, 2'd0},
        {1'b0, 3'd4, 3'd0, 4'd8, 3'd7, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    cas_lat = 3'd3;
    logic [2:0]    add_lat = 3'd0;
    logic [3:0]    burst_len = 4'd4;
    logic [2:0]    wr_rec = 3'd2;
    logic [1:0]    term_code = 2'd0;
    logic          banks_idle = 1'b0;
    logic          cke_on = 1'b0;
    logic          cs_n, ras_n, cas_n, we_n, done, rejected;
    logic [1:0]    ba;
    logic [AW-1:0] addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr2_mrs_seq #(.ADDR_W(AW), .BA_W(2), .TMRD(TMRD_T)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cas_lat(cas_lat), .add_lat(add_lat), .burst_len(burst_len),
        .wr_rec(wr_rec), .term_code(term_code),
        .banks_idle(banks_idle), .cke_on(cke_on),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .done(done), .rejected(rejected)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // hold: negedge index at which readiness rises (0 = ready from the start)
    // use_cke: hold cke_on low instead of banks_idle; disturb: poke inputs mid-run
    task automatic run_seq(input int cl, input int al, input int bl, input int wr,
                           input int term, input bit exp_ok, input int hold,
                           input bit use_cke, input bit disturb);
        int wcount = 0, done_n = 0, done_cyc = -1, rej_n = 0, rej_cyc = -1;
        int nop_bad = 0, early_bad = 0;
        int wcyc[8], wba[8], waddr[8];
        int exp_addr[5], exp_first;
        bit wr_now;

        @(negedge clk);
        cas_lat = 3'(cl); add_lat = 3'(al); burst_len = 4'(bl);
        wr_rec = 3'(wr); term_code = 2'(term);
        banks_idle = use_cke ? 1'b1 : (hold == 0);
        cke_on     = use_cke ? (hold == 0) : 1'b1;
        start = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            wr_now = !cs_n && !ras_n && !cas_n && !we_n;
            if (wr_now && wcount < 8) begin
                wcyc[wcount] = k; wba[wcount] = int'(ba); waddr[wcount] = int'(addr);
                wcount++;
            end
            if (done) begin
                done_n++; done_cyc = k;
                if (!cs_n) nop_bad++;
            end else if (!wr_now && wcount > 0 && done_cyc < 0) begin
                if (!(!cs_n && ras_n && cas_n && we_n && addr == '0)) nop_bad++;
            end
            if (wcount == 0 && !wr_now && !cs_n) early_bad++;
            if (rejected) begin rej_n++; rej_cyc = k; end
            // drive after sampling
            if (k == 1) start = 1'b0;
            if (k == hold) begin banks_idle = 1'b1; cke_on = 1'b1; end
            if (disturb && k == 4) begin
                start = 1'b1; cas_lat = (cl == 3) ? 3'd6 : 3'd3;
                add_lat = 3'd0; burst_len = (bl == 4) ? 4'd8 : 4'd4;
                wr_rec = 3'd4; term_code = ~2'(term);
            end
            if (disturb && k == 5) start = 1'b0;
        end

        if (!exp_ok) begin
            check_eq("R8", "rejected pulses", rej_n, 1);
            check_eq("R8", "rejected cycle", rej_cyc, 1);
            check_eq("R8", "writes after refusal", wcount, 0);
            check_eq("R8", "done after refusal", done_n, 0);
            return;
        end

        exp_addr[0] = ((bl == 8) ? 3 : 2) | (cl << 4) | ((wr - 1) << 9);
        exp_addr[2] = ((term & 1) << 2) | (al << 3) | ((term >> 1) << 6);
        exp_addr[1] = exp_addr[2] | (7 << 7);
        exp_addr[3] = 0;
        exp_addr[4] = 0;
        exp_first   = (hold == 0) ? 2 : hold + 1;

        check_eq("R2", "write count", wcount, 5);
        check_eq("R8", "no refusal on good config", rej_n, 0);
        if (wcount == 5) begin
            check_eq("R2", "bank order code", wba[0]*1000 + wba[1]*100 + wba[2]*10 + wba[3] + wba[4]*10000, 30112 - 1 + 1);
            check_eq("R3", "base register word", waddr[0], exp_addr[0]);
            check_eq("R4", "ext1 calibration default word", waddr[1], exp_addr[1]);
            check_eq("R4", "ext1 calibration exit word", waddr[2], exp_addr[2]);
            check_eq("R5", "ext2 word", waddr[3], 0);
            check_eq("R5", "ext3 word", waddr[4], 0);
            for (int i = 1; i < 5; i++)
                check_eq("R6", "write spacing", wcyc[i] - wcyc[i-1], TMRD_T);
            check_eq("R7", "first write cycle", wcyc[0], exp_first);
            check_eq("R10", "done cycle", done_cyc, wcyc[4] + TMRD_T);
            if (disturb) check_eq("R9", "base word after mid-run change", waddr[0], exp_addr[0]);
        end
        check_eq("R6", "non-nop cycles inside sequence", nop_bad, 0);
        check_eq("R7", "bus active before first write", early_bad, 0);
        check_eq("R10", "done pulses", done_n, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 20000 cycles expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1", "cs_n in reset", int'(cs_n), 1);
        check_eq("R1", "done in reset", int'(done), 0);
        check_eq("R1", "rejected in reset", int'(rejected), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1", "idle bus after reset", int'({cs_n, ba, addr}), 1 << (AW + 2));
        check_eq("R1", "done idle", int'(done), 0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            run_seq(int'(VEC[v][14:12]), int'(VEC[v][11:9]), int'(VEC[v][8:5]),
                    int'(VEC[v][4:2]), int'(VEC[v][1:0]), VEC[v][15], 0, 1'b0, 1'b0);
        end

        // R7: readiness held off by banks, then by clock enable
        run_seq(4, 3, 8, 4, 1, 1'b1, 6, 1'b0, 1'b0);
        run_seq(5, 0, 4, 2, 2, 1'b1, 9, 1'b1, 1'b0);
        // R9: start and configuration changes during a run
        run_seq(3, 4, 4, 6, 3, 1'b1, 0, 1'b0, 1'b1);
        run_seq(6, 2, 8, 3, 0, 1'b1, 3, 1'b0, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule